// File: doc/BRIEF.md
# Backlight PWM controller

This block drives one pulse-width-modulated output for display backlight dimming. Software reaches it through a plain synchronous register port (byte address, write data, write strobe, combinational read data). It programs a clock prescaler, a period count and a high-width count. These settings sit in staging registers and do not touch the waveform until software makes a 0-to-1 transition on a commit bit. A global enable bit gates the output and holds the counters at zero while it is clear.

With prescaler D, period P and high width H, one output cycle lasts (D+1)·(P+1) clock cycles. The output is high for the first (D+1)·H of them. While the block runs, a committed change is held back until the current output cycle ends, so no shortened or stretched pulse appears. While the block is disabled, a commit applies at once.

Top module: `bl_pwm_top`

## Requirements
- R1: After reset every register field reads 0 and `pwm_o` is low.
- R2: Register map: byte offset 0x00 bit 0 is the enable; 0x08 bit 0 is the commit bit; 0x10 bits [25:16] hold the 10-bit prescaler; 0x14 bits [11:0] hold the 12-bit period and bits [28:16] the 13-bit high width. Reads return the staged values. All other bits and all other offsets read 0, and writes to them have no effect.
- R3: While the enable bit is 0, `pwm_o` is low, starting in the cycle after the write that clears it.
- R4: One output cycle lasts (D+1)·(P+1) clock cycles, and the pattern repeats with that length.
- R5: For 1 ≤ H ≤ P, the output is high for the first (D+1)·H clock cycles of each output cycle and low for the rest.
- R6: With H = 0 the output stays low while enabled.
- R7: With H ≥ P+1 the output stays high while enabled.
- R8: Writes to the prescaler, period or high-width fields leave the waveform unchanged until a commit edge. A write of 1 to the commit bit while it already holds 1 is not an edge and changes nothing.
- R9: While enabled, a commit edge makes the staged settings active at the first output-cycle boundary after it. The running output cycle finishes with the old settings.
- R10: While disabled, a commit edge makes the staged settings active at once, so the first output cycle after enabling uses them.
- R11: When enable goes from 0 to 1, both counters restart from zero. The first clock cycle after the enabling write is high unless H = 0.
- R12: A commit edge written in the last clock cycle of an output cycle takes effect at that same boundary, not one output cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pwm_o | output | 1 | PWM output |

## Verification
Two events can fall in the same cycle: a commit edge arriving from the register port, and the period-boundary load of the shadow settings. The bench runs an 8-cycle output cycle and places the commit write in cycle 6, cycle 7 (the boundary cycle itself) and cycle 8. In the first two cases the new 2-cycle pattern must start at cycle 8. In the last case it must start at cycle 16. Each case is judged by comparing every sampled output cycle against an arithmetic model of the old and new settings.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
  // Register byte offsets
  localparam int unsigned OFS_ENABLE = 32'h00;
  localparam int unsigned OFS_COMMIT = 32'h08;
  localparam int unsigned OFS_DIV    = 32'h10;
  localparam int unsigned OFS_SHAPE  = 32'h14;
  // Field positions inside the data word
  localparam int unsigned DIV_LSB  = 16;
  localparam int unsigned PER_LSB  = 0;
  localparam int unsigned HIGH_LSB = 16;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_EN,
    SEL_COMMIT,
    SEL_DIV,
    SEL_SHAPE
  } reg_sel_e;
endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
  import bl_pwm_pkg::*;
#(
  parameter int unsigned DIV_W  = 10,
  parameter int unsigned PER_W  = 12,
  parameter int unsigned HIGH_W = 13,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr,
  output logic [DATA_W-1:0] rdata,
  output logic              en,
  output logic              commit_edge,
  output logic [DIV_W-1:0]  div_stg,
  output logic [PER_W-1:0]  per_stg,
  output logic [HIGH_W-1:0] high_stg
);
  reg_sel_e sel;
  logic en_q, cmt_q;
  logic [DIV_W-1:0]  div_q;
  logic [PER_W-1:0]  per_q;
  logic [HIGH_W-1:0] high_q;
  logic ce_en, ce_cmt, ce_div, ce_shape;
  logic unused_wdata;

  assign unused_wdata = ^wdata;

  // Address decode
  always_comb begin
    case (addr)
      ADDR_W'(OFS_ENABLE): sel = SEL_EN;
      ADDR_W'(OFS_COMMIT): sel = SEL_COMMIT;
      ADDR_W'(OFS_DIV):    sel = SEL_DIV;
      ADDR_W'(OFS_SHAPE):  sel = SEL_SHAPE;
      default:             sel = SEL_NONE;
    endcase
  end

  // Clock enables
  always_comb begin
    ce_en       = wr && (sel == SEL_EN);
    ce_cmt      = wr && (sel == SEL_COMMIT);
    ce_div      = wr && (sel == SEL_DIV);
    ce_shape    = wr && (sel == SEL_SHAPE);
    commit_edge = ce_cmt && wdata[0] && !cmt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      cmt_q  <= 1'b0;
      div_q  <= '0;
      per_q  <= '0;
      high_q <= '0;
    end else begin
      if (ce_en)    en_q   <= wdata[0];
      if (ce_cmt)   cmt_q  <= wdata[0];
      if (ce_div)   div_q  <= wdata[DIV_LSB +: DIV_W];
      if (ce_shape) per_q  <= wdata[PER_LSB +: PER_W];
      if (ce_shape) high_q <= wdata[HIGH_LSB +: HIGH_W];
    end
  end

  // Read mux: unused bits stay zero
  always_comb begin
    rdata = '0;
    case (sel)
      SEL_EN:     rdata[0] = en_q;
      SEL_COMMIT: rdata[0] = cmt_q;
      SEL_DIV:    rdata[DIV_LSB +: DIV_W] = div_q;
      SEL_SHAPE: begin
        rdata[PER_LSB +: PER_W]   = per_q;
        rdata[HIGH_LSB +: HIGH_W] = high_q;
      end
      default:    rdata = '0;
    endcase
  end

  assign en       = en_q;
  assign div_stg  = div_q;
  assign per_stg  = per_q;
  assign high_stg = high_q;
endmodule

// File: rtl/bl_pwm_shadow.sv
module bl_pwm_shadow #(
  parameter int unsigned DIV_W  = 10,
  parameter int unsigned PER_W  = 12,
  parameter int unsigned HIGH_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              commit_edge,
  input  logic              at_end,
  input  logic [DIV_W-1:0]  div_stg,
  input  logic [PER_W-1:0]  per_stg,
  input  logic [HIGH_W-1:0] high_stg,
  output logic [DIV_W-1:0]  div_act,
  output logic [PER_W-1:0]  per_act,
  output logic [HIGH_W-1:0] high_act
);
  logic pend_q, pend_d, req, load;

  // A fresh edge counts in its own cycle, so an edge on the boundary loads there
  always_comb begin
    req    = pend_q || commit_edge;
    load   = req && (!en || at_end);
    pend_d = req && !load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      div_act  <= '0;
      per_act  <= '0;
      high_act <= '0;
    end else begin
      pend_q <= pend_d;
      if (load) begin
        div_act  <= div_stg;
        per_act  <= per_stg;
        high_act <= high_stg;
      end
    end
  end
endmodule

// File: rtl/bl_pwm_core.sv
module bl_pwm_core #(
  parameter int unsigned DIV_W  = 10,
  parameter int unsigned PER_W  = 12,
  parameter int unsigned HIGH_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DIV_W-1:0]  div,
  input  logic [PER_W-1:0]  per,
  input  logic [HIGH_W-1:0] high,
  output logic [DIV_W-1:0]  pre_cnt,
  output logic [PER_W-1:0]  per_cnt,
  output logic              at_end,
  output logic              pwm
);
  localparam int unsigned CMP_W = (HIGH_W > PER_W) ? HIGH_W : PER_W;

  logic [DIV_W-1:0] pre_q, pre_d;
  logic [PER_W-1:0] per_q, per_d;
  logic tick, per_last;

  always_comb begin
    tick     = (pre_q == div);
    per_last = (per_q == per);
    at_end   = en && tick && per_last;
    if (!en) begin
      pre_d = '0;
      per_d = '0;
    end else if (tick) begin
      pre_d = '0;
      per_d = per_last ? '0 : per_q + 1'b1;
    end else begin
      pre_d = pre_q + 1'b1;
      per_d = per_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      per_q <= '0;
    end else begin
      pre_q <= pre_d;
      per_q <= per_d;
    end
  end

  assign pwm     = en && (CMP_W'(per_q) < CMP_W'(high));
  assign pre_cnt = pre_q;
  assign per_cnt = per_q;
endmodule

// File: rtl/bl_pwm_top.sv
module bl_pwm_top #(
  parameter int unsigned DIV_W  = 10,
  parameter int unsigned PER_W  = 12,
  parameter int unsigned HIGH_W = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  input  logic        reg_wr,
  output logic [31:0] reg_rdata,
  output logic        pwm_o
);
  logic [1:0] rst_pipe;
  logic rst_q_n;
  logic en_q, commit_edge, at_end;
  logic [DIV_W-1:0]  div_stg, div_act, pre_cnt;
  logic [PER_W-1:0]  per_stg, per_act, per_cnt;
  logic [HIGH_W-1:0] high_stg, high_act;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  bl_pwm_regs #(.DIV_W(DIV_W), .PER_W(PER_W), .HIGH_W(HIGH_W),
                .ADDR_W(8), .DATA_W(32)) u_regs (
    .clk(clk), .rst_n(rst_q_n), .addr(reg_addr), .wdata(reg_wdata),
    .wr(reg_wr), .rdata(reg_rdata), .en(en_q), .commit_edge(commit_edge),
    .div_stg(div_stg), .per_stg(per_stg), .high_stg(high_stg)
  );

  bl_pwm_shadow #(.DIV_W(DIV_W), .PER_W(PER_W), .HIGH_W(HIGH_W)) u_shadow (
    .clk(clk), .rst_n(rst_q_n), .en(en_q), .commit_edge(commit_edge),
    .at_end(at_end), .div_stg(div_stg), .per_stg(per_stg),
    .high_stg(high_stg), .div_act(div_act), .per_act(per_act),
    .high_act(high_act)
  );

  bl_pwm_core #(.DIV_W(DIV_W), .PER_W(PER_W), .HIGH_W(HIGH_W)) u_core (
    .clk(clk), .rst_n(rst_q_n), .en(en_q), .div(div_act), .per(per_act),
    .high(high_act), .pre_cnt(pre_cnt), .per_cnt(per_cnt),
    .at_end(at_end), .pwm(pwm_o)
  );
endmodule

// File: rtl/bl_pwm_chk.sv
module bl_pwm_chk #(
  parameter int unsigned DIV_W  = 10,
  parameter int unsigned PER_W  = 12,
  parameter int unsigned HIGH_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              at_end,
  input logic [DIV_W-1:0]  pre_cnt,
  input logic [PER_W-1:0]  per_cnt,
  input logic [DIV_W-1:0]  div_act,
  input logic [PER_W-1:0]  per_act,
  input logic [HIGH_W-1:0] high_act,
  input logic              pwm,
  input logic [7:0]        addr,
  input logic [31:0]       rdata
);
  a_r3_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !pwm);

  a_r6_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
    (high_act == '0) |-> !pwm);

  a_r7_full_high: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (32'(high_act) > 32'(per_act))) |-> pwm);

  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pre_cnt == div_act && per_cnt == per_act)
      |=> (pre_cnt == '0 && per_cnt == '0));

  a_r9_hold_active: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !at_end) |=> $stable({div_act, per_act, high_act}));

  a_r11_restart: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(en) && high_act != '0) |-> (pwm && pre_cnt == '0 && per_cnt == '0));

  a_r2_div_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 8'h10) |-> (rdata[31:26] == 6'd0 && rdata[15:0] == 16'd0));
endmodule

bind bl_pwm_top bl_pwm_chk #(.DIV_W(DIV_W), .PER_W(PER_W), .HIGH_W(HIGH_W)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .en(en_q), .at_end(at_end),
  .pre_cnt(pre_cnt), .per_cnt(per_cnt), .div_act(div_act),
  .per_act(per_act), .high_act(high_act), .pwm(pwm_o),
  .addr(reg_addr), .rdata(reg_rdata)
);

// File: tb/test_bl_pwm_top.sv
module test_bl_pwm_top;
  logic        clk;
  logic        rst_n;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic        reg_wr;
  logic [31:0] reg_rdata;
  logic        pwm_o;

  int checks;
  int failures;
  bit done;

  bl_pwm_top i_bl_pwm_top (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rdata(reg_rdata), .pwm_o(pwm_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic model(int d, int p, int h, int pos);
    int len = (d + 1) * (p + 1);
    int ph  = pos % len;
    return (ph / (d + 1)) < h;
  endfunction

  function automatic logic [31:0] shape(int p, int h);
    return (32'(h) << 16) | 32'(p);
  endfunction

  task automatic setup(input int d, input int p, input int h, input bit hold);
    wr(8'h00, 32'd0);
    wr(8'h10, 32'(d) << 16);
    wr(8'h14, shape(p, h));
    wr(8'h08, 32'd1);
    if (!hold) wr(8'h08, 32'd0);
    wr(8'h00, 32'd1);
  endtask

  // Old settings run from cycle 0; new ones expected from switch_at on
  task automatic run_sched(input int od, input int op, input int oh,
                           input int nd, input int np, input int nh,
                           input int cmt_at, input int switch_at, input int n,
                           input bit hold, input string req);
    int errs = 0;
    int bad_i = -1;
    logic exp_v, got_v;
    logic exp_b = 1'b0;
    logic got_b = 1'b0;
    setup(od, op, oh, hold);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reg_wr = 1'b0;
      if (i == 0) begin reg_addr = 8'h10; reg_wdata = 32'(nd) << 16; reg_wr = 1'b1; end
      if (i == 1) begin reg_addr = 8'h14; reg_wdata = shape(np, nh); reg_wr = 1'b1; end
      if (i == cmt_at) begin reg_addr = 8'h08; reg_wdata = 32'd1; reg_wr = 1'b1; end
      if (i == cmt_at + 1) begin reg_addr = 8'h08; reg_wdata = 32'd0; reg_wr = 1'b1; end
      exp_v = (i < switch_at) ? model(od, op, oh, i) : model(nd, np, nh, i - switch_at);
      got_v = pwm_o;
      if (got_v !== exp_v) begin
        if (errs == 0) begin bad_i = i; exp_b = exp_v; got_b = got_v; end
        errs++;
      end
    end
    @(negedge clk);
    reg_wr = 1'b0;
    check(errs == 0, req, $sformatf("commit at %0d: cycle %0d pwm actual %0b expected %0b",
                                    cmt_at, bad_i, got_b, exp_b));
  endtask

  initial begin
    logic [31:0] v;
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0; reg_addr = '0; reg_wdata = '0; reg_wr = 1'b0;
    repeat (3) @(posedge clk);

    // R1: reset values
    @(negedge clk);
    check(pwm_o == 1'b0, "R1", $sformatf("pwm in reset actual %0b expected 0", pwm_o));
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    rd(8'h00, v); check(v == 32'd0, "R1", $sformatf("enable reg actual %h expected 0", v));
    rd(8'h08, v); check(v == 32'd0, "R1", $sformatf("commit reg actual %h expected 0", v));
    rd(8'h10, v); check(v == 32'd0, "R1", $sformatf("div reg actual %h expected 0", v));
    rd(8'h14, v); check(v == 32'd0, "R1", $sformatf("shape reg actual %h expected 0", v));
    check(pwm_o == 1'b0, "R1", $sformatf("pwm after reset actual %0b expected 0", pwm_o));

    // R2: field positions, reserved bits, unmapped offsets
    wr(8'h14, 32'hFFFF_FFFF); rd(8'h14, v);
    check(v == 32'h1FFF_0FFF, "R2", $sformatf("shape actual %h expected 1fff0fff", v));
    wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, v);
    check(v == 32'h03FF_0000, "R2", $sformatf("div actual %h expected 03ff0000", v));
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, v);
    check(v == 32'd0, "R2", $sformatf("unmapped actual %h expected 0", v));
    rd(8'h0C, v); check(v == 32'd0, "R2", $sformatf("unmapped 0c actual %h expected 0", v));
    wr(8'h10, 32'h0005_0000); wr(8'h1C, 32'hFFFF_FFFF); rd(8'h10, v);
    check(v == 32'h0005_0000, "R2", $sformatf("div after stray write actual %h expected 50000", v));
    wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, v);
    check(v == 32'd1, "R2", $sformatf("commit actual %h expected 1", v));
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, v);
    check(v == 32'd1, "R2", $sformatf("enable actual %h expected 1", v));
    wr(8'h00, 32'd0); wr(8'h08, 32'd0);

    // Sweep: R4 R5 R6 R7 R10 R11 over small settings
    for (int d = 0; d < 4; d++) begin
      for (int p = 0; p < 5; p++) begin
        for (int h = 0; h < p + 4; h++) begin
          int errs = 0;
          int len = (d + 1) * (p + 1);
          int bad_i = -1;
          logic got_b = 1'b0;
          logic exp_b = 1'b0;
          string tag;
          setup(d, p, h, 1'b0);
          for (int i = 0; i < 2 * len; i++) begin
            @(negedge clk);
            if (pwm_o !== model(d, p, h, i)) begin
              if (errs == 0) begin bad_i = i; got_b = pwm_o; exp_b = model(d, p, h, i); end
              errs++;
            end
          end
          if (h == 0)     tag = "R6 R4 R10 R11";
          else if (h > p) tag = "R7 R4 R10 R11";
          else            tag = "R5 R4 R10 R11";
          check(errs == 0, tag, $sformatf("d=%0d p=%0d h=%0d cycle %0d actual %0b expected %0b",
                                          d, p, h, bad_i, got_b, exp_b));
        end
      end
    end

    // R3: clearing enable forces low from the next cycle
    begin
      int errs = 0;
      setup(0, 2, 7, 1'b0);
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        reg_wr = 1'b0;
        if (i == 1) begin reg_addr = 8'h00; reg_wdata = 32'd0; reg_wr = 1'b1; end
        if (pwm_o !== (i <= 1)) errs++;
      end
      @(negedge clk); reg_wr = 1'b0;
      check(errs == 0, "R3", $sformatf("mismatching cycles actual %0d expected 0", errs));
    end

    // R11: re-enable mid-cycle restarts from zero
    begin
      int errs = 0;
      setup(1, 3, 2, 1'b0);
      repeat (3) @(negedge clk);
      wr(8'h00, 32'd0);
      wr(8'h00, 32'd1);
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (pwm_o !== model(1, 3, 2, i)) errs++;
      end
      check(errs == 0, "R11", $sformatf("mismatching cycles actual %0d expected 0", errs));
    end

    // R8: staging without commit, and commit written 1 while already 1
    run_sched(1, 3, 2, 0, 1, 1, -5, 1000, 24, 1'b0, "R8");
    run_sched(1, 3, 2, 0, 1, 1, 4, 1000, 24, 1'b1, "R8");
    // R9: commit mid-cycle waits for the boundary at cycle 8
    run_sched(1, 3, 2, 0, 1, 1, 4, 8, 20, 1'b0, "R9");
    run_sched(1, 3, 2, 0, 1, 1, 6, 8, 20, 1'b0, "R9");
    // R12: commit in the boundary cycle applies there; one later waits a full cycle
    run_sched(1, 3, 2, 0, 1, 1, 7, 8, 20, 1'b0, "R12");
    run_sched(1, 3, 2, 0, 1, 1, 8, 16, 24, 1'b0, "R12");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule